// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one read or one write transfer at a time on an external bus whose sixteen low lines carry the address first and the data afterwards. A request is presented on a simple internal port: a 20-bit address, two byte enables, a read/write flag, a memory/I-O flag and write data. The request is accepted in one clock. The sequencer then walks the bus through its clock states, T1, T2, T3, any wait states and T4.

In T1 the sequencer puts the address on the shared lines and the four upper lines, and it pulses an address strobe so that an outside latch can hold the address. From T2 on, the shared lines carry data. The upper lines and the high-byte enable then carry status. The read or write strobe and the transceiver enable are active during T2, T3 and every wait state. A ready input adds one wait state for each clock in which it is sampled low. Read data is taken from the bus on the edge that leaves the last active state, and it is returned with a one-clock response pulse in T4.

Between transfers, an outside bus master can request the bus. The sequencer grants it and then floats every bus output until the request is withdrawn. Reset is active low and synchronous. It only takes effect after it has been sampled low on four edges in a row.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `addr_strobe` is 1 and `ad_oe` is 1. `ad_out` equals address bits 15:0 and `up_out` equals address bits 19:16. `hi_byte_n` equals the inverse of byte-enable bit 1. `mem_sel` is 1 for memory and 0 for I/O. `xcvr_dir_tx` is 1 for a write. Both strobes and `xcvr_en_n` are 1.
- R2: From T2 through T4, `up_out` carries the status nibble {be[1], be[0], write, mem} in bit order 3 to 0. `hi_byte_n` is 1 and `addr_strobe` is 0.
- R3: In a read, `rd_strb_n` and `xcvr_en_n` are 0 in T2, T3 and each wait state. `ad_oe` is 0 from T2 through T4, and `xcvr_dir_tx` is 0.
- R4: In a write, `wr_strb_n` and `xcvr_en_n` are 0 in T2, T3 and each wait state. `ad_oe` is 1 and `ad_out` carries the write data (low byte on bits 7:0, high byte on bits 15:8) from T2 through T4.
- R5: `rsp_valid` is 1 for exactly the T4 clock. For a read, `rsp_rdata` in T4 equals `ad_in` as sampled on the edge that leaves T3 or the last wait state. It does not take the value from any earlier or later edge.
- R6: Each edge that leaves T3 or a wait state with `bus_rdy` at 0 adds one more wait state, and the active strobe stays low through it. An edge with `bus_rdy` at 1 moves the sequencer to T4.
- R7: `rd_strb_n` and `wr_strb_n` are never 0 together. While `addr_strobe` is 1, neither strobe is 0 and `xcvr_en_n` is 1.
- R8: `req_ready` is 1 only when the sequencer is idle and `hold_req` is 0. An accepted request starts T1 on the next clock, and `req_ready` is 0 until the clock after T4.
- R9: `hold_req` is sampled only when idle or in T4. Once it is sampled at 1, `bus_grant` is 1 from the next clock, and it outranks a pending request. While the grant holds, `ad_oe`, `ctl_oe` and `req_ready` are all 0.
- R10: `bus_grant` returns to 0 one clock after `hold_req` is sampled at 0. It does not fall in the same clock that `hold_req` falls.
- R11: A hold request that arrives during T1 to the last wait state does not cut the transfer short. T4 completes with `bus_grant` at 0, and `bus_grant` becomes 1 on the clock after T4.
- R12: When `rst_n` is sampled low on four consecutive edges, the sequencer goes idle, with `addr_strobe` 0, both strobes 1, `xcvr_en_n` 1, `ad_oe` 0, `bus_grant` 0 and `rsp_valid` 0. A shorter low pulse leaves a transfer in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, qualified over four edges |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Transfer address |
| req_be | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Transfer finishing (T4) |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_in | input | 16 | Shared address/data lines, sampled value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| up_out | output | 4 | Upper address in T1, status afterwards |
| hi_byte_n | output | 1 | Active-low high-byte enable in T1 |
| addr_strobe | output | 1 | Active-high address latch strobe |
| rd_strb_n | output | 1 | Active-low read strobe |
| wr_strb_n | output | 1 | Active-low write strobe |
| xcvr_en_n | output | 1 | Active-low data transceiver enable |
| xcvr_dir_tx | output | 1 | Transceiver direction, 1 outbound |
| mem_sel | output | 1 | 1 memory, 0 I/O |
| ctl_oe | output | 1 | Drive enable for control and upper lines |
| bus_rdy | input | 1 | Ready from the addressed device |
| hold_req | input | 1 | Bus request from another master |
| bus_grant | output | 1 | Bus granted to the other master |

## Verification
The bench varies the wait-state count and changes the value on the shared lines from one wait state to the next. A sequencer that samples read data on the wrong edge then returns a wrong word, and one that miscounts wait states releases its strobe in a state where it should still be low. A hold request is raised in the middle of a transfer, which catches a design that floats the bus before T4 or never grants it. A hold request is also raised together with a pending request, which catches a design that starts a transfer under hold. For reset, a two-clock pulse in the middle of a transfer must leave the transfer running to completion, while a four-clock pulse must abort it. This separates a design that resets on the first low sample from one that never qualifies the reset at all.

// File: rtl/muxbus_pkg.sv
// Package: shared state type for the multiplexed bus sequencer.
// Assumes: one transfer at a time; a single idle clock between transfers.
package muxbus_pkg;

    // Bus clock states plus idle and granted-away states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } seq_state_t;

endpackage

// File: rtl/muxbus_rst_qual.sv
// Module: reset qualifier.
// Turns a synchronous active-low reset into an internal reset pulse that
// only fires once rst_n has been sampled low on RST_CYC consecutive edges.
// Assumes: RST_CYC >= 2.
module muxbus_rst_qual #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_apply
);
    localparam int CW = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples of rst_n, saturating at LAST
    always_ff @(posedge clk) begin
        if (rst_n)
            low_cnt <= '0;
        else if (low_cnt < LAST)
            low_cnt <= low_cnt + 1'b1;
    end

    assign rst_apply = !rst_n && (low_cnt >= LAST);

endmodule

// File: rtl/muxbus_fsm.sv
// Module: sequencer state machine.
// Accepts one request at a time, steps through T1..T4 with wait states
// while bus_rdy is low, captures read data on the ready edge, and hands
// the bus away on hold_req only between transfers.
// Assumes: ad_in is stable around the ready edge.
module muxbus_fsm
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_apply,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_rdy,
    input  logic              hold_req,
    input  logic [DATA_W-1:0] ad_in,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W/8-1:0] lat_be,
    output logic              lat_write,
    output logic              lat_mem,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    seq_state_t state_nx;
    logic       accept;
    logic       rdy_edge;

    assign req_ready = (state == ST_IDLE) && !hold_req;
    assign accept    = req_ready && req_valid;
    assign rdy_edge  = ((state == ST_T3) || (state == ST_TW)) && bus_rdy;
    assign rsp_valid = (state == ST_T4);

    // Next-state selection for the bus clock states
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hold_req)       state_nx = ST_HOLD;
                else if (req_valid) state_nx = ST_T1;
            end
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3,
            ST_TW:   state_nx = bus_rdy ? ST_T4 : ST_TW;
            ST_T4:   state_nx = hold_req ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nx = hold_req ? ST_HOLD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with qualified reset
    always_ff @(posedge clk) begin
        if (rst_apply)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Latch request fields when a request is accepted
    always_ff @(posedge clk) begin
        if (rst_apply) begin
            lat_addr  <= '0;
            lat_be    <= '0;
            lat_write <= 1'b0;
            lat_mem   <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_be    <= req_be;
            lat_write <= req_write;
            lat_mem   <= req_mem;
            lat_wdata <= req_wdata;
        end
    end

    // Capture read data on the edge that leaves the last active state
    always_ff @(posedge clk) begin
        if (rst_apply)
            rsp_rdata <= '0;
        else if (rdy_edge && !lat_write)
            rsp_rdata <= ad_in;
    end

    // R6
    wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !bus_rdy) |=> (state == ST_TW));

    // R8
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (state == ST_T1 && lat_addr == $past(req_addr)));

    // R10
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hold_req) |=> (state == ST_IDLE));

    // R11
    no_midcycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1 || state == ST_T2 || state == ST_T3 || state == ST_TW)
        |=> (state != ST_HOLD));

endmodule

// File: rtl/muxbus_drive.sv
// Module: pin decoder.
// Derives every bus pin value and drive enable from the current state and
// the latched request. Purely combinational; all pin timing follows state.
// Assumes: ADDR_W > DATA_W; the upper lines carry ADDR_W-DATA_W bits.
module muxbus_drive
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W/8-1:0] lat_be,
    input  logic              lat_write,
    input  logic              lat_mem,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] up_out,
    output logic              hi_byte_n,
    output logic              addr_strobe,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              xcvr_en_n,
    output logic              xcvr_dir_tx,
    output logic              mem_sel,
    output logic              ctl_oe,
    output logic              bus_grant
);
    localparam int UP_W = ADDR_W - DATA_W;
    localparam int BE_W = DATA_W / 8;

    logic [UP_W-1:0] status_nib;
    logic            strobe_phase;

    assign status_nib   = UP_W'({lat_be, lat_write, lat_mem});
    assign strobe_phase = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);

    // Decode pin values for the current bus state
    always_comb begin
        ad_out      = '0;
        ad_oe       = 1'b0;
        up_out      = '0;
        hi_byte_n   = 1'b1;
        addr_strobe = 1'b0;
        rd_strb_n   = 1'b1;
        wr_strb_n   = 1'b1;
        xcvr_en_n   = 1'b1;
        xcvr_dir_tx = lat_write;
        mem_sel     = lat_mem;
        ctl_oe      = (state != ST_HOLD);
        bus_grant   = (state == ST_HOLD);
        if (state == ST_T1) begin
            ad_out      = lat_addr[DATA_W-1:0];
            ad_oe       = 1'b1;
            up_out      = lat_addr[ADDR_W-1:DATA_W];
            hi_byte_n   = ~lat_be[BE_W-1];
            addr_strobe = 1'b1;
        end else if (strobe_phase || state == ST_T4) begin
            up_out = status_nib;
            if (lat_write) begin
                ad_out = lat_wdata;
                ad_oe  = 1'b1;
            end
            if (strobe_phase) begin
                xcvr_en_n = 1'b0;
                rd_strb_n = lat_write;
                wr_strb_n = !lat_write;
            end
        end
    end

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strb_n && !wr_strb_n));

    // R7
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (rd_strb_n && wr_strb_n && xcvr_en_n));

    // R9
    float_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (!ad_oe && !ctl_oe));

    // R3
    read_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strb_n) |-> $past(addr_strobe));

endmodule

// File: rtl/mux_bus_seq.sv
// Module: multiplexed address/data bus cycle sequencer (top).
// Joins the reset qualifier, the state machine and the pin decoder.
// Assumes: outside tri-state buffers honour ad_oe and ctl_oe.
module mux_bus_seq #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] up_out,
    output logic              hi_byte_n,
    output logic              addr_strobe,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              xcvr_en_n,
    output logic              xcvr_dir_tx,
    output logic              mem_sel,
    output logic              ctl_oe,
    input  logic              bus_rdy,
    input  logic              hold_req,
    output logic              bus_grant
);
    localparam int BE_W = DATA_W / 8;

    logic                   rst_apply;
    muxbus_pkg::seq_state_t state;
    logic [ADDR_W-1:0]      lat_addr;
    logic [BE_W-1:0]        lat_be;
    logic                   lat_write;
    logic                   lat_mem;
    logic [DATA_W-1:0]      lat_wdata;

    muxbus_rst_qual #(.RST_CYC(RST_CYC)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_apply (rst_apply)
    );

    muxbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_apply (rst_apply),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_wdata (req_wdata),
        .bus_rdy   (bus_rdy),
        .hold_req  (hold_req),
        .ad_in     (ad_in),
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_be    (lat_be),
        .lat_write (lat_write),
        .lat_mem   (lat_mem),
        .lat_wdata (lat_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    muxbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .lat_addr    (lat_addr),
        .lat_be      (lat_be),
        .lat_write   (lat_write),
        .lat_mem     (lat_mem),
        .lat_wdata   (lat_wdata),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .up_out      (up_out),
        .hi_byte_n   (hi_byte_n),
        .addr_strobe (addr_strobe),
        .rd_strb_n   (rd_strb_n),
        .wr_strb_n   (wr_strb_n),
        .xcvr_en_n   (xcvr_en_n),
        .xcvr_dir_tx (xcvr_dir_tx),
        .mem_sel     (mem_sel),
        .ctl_oe      (ctl_oe),
        .bus_grant   (bus_grant)
    );

endmodule

// File: tb/mux_bus_seq_tb.sv
`timescale 1ns/1ps
module mux_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] ad_out;
    logic [15:0] ad_in = 16'hDEAD;
    logic        ad_oe;
    logic [3:0]  up_out;
    logic        hi_byte_n, addr_strobe, rd_strb_n, wr_strb_n;
    logic        xcvr_en_n, xcvr_dir_tx, mem_sel, ctl_oe;
    logic        bus_rdy = 1'b1;
    logic        hold_req = 1'b0;
    logic        bus_grant;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .req_write(req_write),
        .req_mem(req_mem), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
        .up_out(up_out), .hi_byte_n(hi_byte_n), .addr_strobe(addr_strobe),
        .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n), .xcvr_en_n(xcvr_en_n),
        .xcvr_dir_tx(xcvr_dir_tx), .mem_sel(mem_sel), .ctl_oe(ctl_oe),
        .bus_rdy(bus_rdy), .hold_req(hold_req), .bus_grant(bus_grant)
    );

    // Vector: {write, mem, be[1:0], waits[2:0], addr[19:0], data[15:0]}
    localparam logic [42:0] VEC [6] = '{
        {1'b0, 1'b1, 2'b11, 3'd0, 20'hA1234, 16'h5AC3},
        {1'b1, 1'b1, 2'b11, 3'd0, 20'h30F0E, 16'hBEEF},
        {1'b0, 1'b0, 2'b01, 3'd2, 20'h003F8, 16'h00A5},
        {1'b1, 1'b0, 2'b10, 3'd1, 20'h00061, 16'h7700},
        {1'b0, 1'b1, 2'b10, 3'd3, 20'hFFFFF, 16'h8001},
        {1'b1, 1'b1, 2'b01, 3'd0, 20'h80000, 16'h0042}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [42:0] v, input bit hold_mid, input bit rst_mid);
        logic        wr    = v[42];
        logic        mem   = v[41];
        logic [1:0]  be    = v[40:39];
        logic [2:0]  waits = v[38:36];
        logic [19:0] addr  = v[35:16];
        logic [15:0] data  = v[15:0];
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready idle", req_ready, 1);
        req_addr = addr; req_be = be; req_write = wr; req_mem = mem;
        req_wdata = data; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);           // T1
        req_valid = 1'b0;
        chk(addr_strobe == 1'b1 && ad_oe == 1'b1, "R1 strobe/oe", {addr_strobe, ad_oe}, 2'b11);
        chk(ad_out == addr[15:0], "R1 low addr", ad_out, addr[15:0]);
        chk(up_out == addr[19:16], "R1 up addr", up_out, addr[19:16]);
        chk(hi_byte_n == ~be[1], "R1 hi byte", hi_byte_n, ~be[1]);
        chk(mem_sel == mem && xcvr_dir_tx == wr, "R1 sel/dir", {mem_sel, xcvr_dir_tx}, {mem, wr});
        chk(rd_strb_n && wr_strb_n && xcvr_en_n, "R1 idle strobes",
            {rd_strb_n, wr_strb_n, xcvr_en_n}, 3'b111);
        @(posedge clk); @(negedge clk);           // T2
        chk(up_out == {be, wr, mem}, "R2 status", up_out, {be, wr, mem});
        chk(hi_byte_n == 1'b1 && addr_strobe == 1'b0, "R2 hi/strobe", {hi_byte_n, addr_strobe}, 2'b10);
        chk(req_ready == 1'b0, "R8 busy", req_ready, 0);
        if (wr) begin
            chk(wr_strb_n == 1'b0 && rd_strb_n == 1'b1 && xcvr_en_n == 1'b0, "R4 T2 strobes",
                {rd_strb_n, wr_strb_n, xcvr_en_n}, 3'b100);
            chk(ad_oe == 1'b1 && ad_out == data, "R4 T2 data", ad_out, data);
        end else begin
            chk(rd_strb_n == 1'b0 && wr_strb_n == 1'b1 && xcvr_en_n == 1'b0, "R3 T2 strobes",
                {rd_strb_n, wr_strb_n, xcvr_en_n}, 3'b010);
            chk(ad_oe == 1'b0 && xcvr_dir_tx == 1'b0, "R3 T2 float", {ad_oe, xcvr_dir_tx}, 2'b00);
        end
        if (hold_mid) hold_req = 1'b1;
        if (rst_mid) rst_n = 1'b0;
        @(posedge clk); @(negedge clk);           // T3
        chk((wr ? wr_strb_n : rd_strb_n) == 1'b0, "R6 T3 strobe", wr ? wr_strb_n : rd_strb_n, 0);
        chk(bus_grant == 1'b0, "R11 no early grant", bus_grant, 0);
        bus_rdy = (waits == 0);
        ad_in   = (waits == 0) ? data : 16'h1111;
        @(posedge clk);
        for (int i = 0; i < int'(waits); i++) begin
            @(negedge clk);                       // wait state
            chk((wr ? wr_strb_n : rd_strb_n) == 1'b0 && xcvr_en_n == 1'b0, "R6 wait strobe",
                {wr ? wr_strb_n : rd_strb_n, xcvr_en_n}, 2'b00);
            chk(rsp_valid == 1'b0, "R6 no early end", rsp_valid, 0);
            bus_rdy = (i == int'(waits) - 1);
            ad_in   = (i == int'(waits) - 1) ? data : 16'h1111;
            @(posedge clk);
        end
        @(negedge clk);                           // T4
        ad_in = 16'hDEAD; bus_rdy = 1'b1;
        if (rst_mid) rst_n = 1'b1;
        chk(rsp_valid == 1'b1, "R5 T4 valid", rsp_valid, 1);
        chk(rd_strb_n && wr_strb_n && xcvr_en_n, "R5 T4 strobes off",
            {rd_strb_n, wr_strb_n, xcvr_en_n}, 3'b111);
        if (wr) chk(ad_oe == 1'b1 && ad_out == data, "R4 T4 data", ad_out, data);
        else    chk(rsp_rdata == data, "R5 read data", rsp_rdata, data);
        chk(bus_grant == 1'b0, "R11 T4 not granted", bus_grant, 0);
        @(posedge clk); @(negedge clk);           // after T4
        chk(rsp_valid == 1'b0, "R5 one clock", rsp_valid, 0);
        if (hold_mid) begin
            chk(bus_grant == 1'b1 && ad_oe == 1'b0 && ctl_oe == 1'b0, "R11 grant after T4",
                {bus_grant, ad_oe, ctl_oe}, 3'b100);
            hold_req = 1'b0;
            @(posedge clk); @(negedge clk);
            chk(bus_grant == 1'b0, "R10 release", bus_grant, 0);
        end else begin
            chk(req_ready == 1'b1, "R8 ready again", req_ready, 1);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R12 initial reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(addr_strobe == 1'b0 && rd_strb_n && wr_strb_n && xcvr_en_n, "R12 reset strobes",
            {addr_strobe, rd_strb_n, wr_strb_n, xcvr_en_n}, 4'b0111);
        chk(ad_oe == 1'b0 && bus_grant == 1'b0 && rsp_valid == 1'b0, "R12 reset outputs",
            {ad_oe, bus_grant, rsp_valid}, 3'b000);
        rst_n = 1'b1;

        // Vector walk: R1 to R8
        for (int k = 0; k < 6; k++) run_vec(VEC[k], 1'b0, 1'b0);

        // R9 hold while idle outranks a pending request
        @(negedge clk);
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 20'h12345; req_write = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(bus_grant == 1'b1, "R9 grant", bus_grant, 1);
        chk(ad_oe == 1'b0 && ctl_oe == 1'b0 && req_ready == 1'b0, "R9 float",
            {ad_oe, ctl_oe, req_ready}, 3'b000);
        @(posedge clk); @(negedge clk);
        chk(addr_strobe == 1'b0 && bus_grant == 1'b1, "R9 no start",
            {addr_strobe, bus_grant}, 2'b01);
        hold_req = 1'b0; req_valid = 1'b0;
        #1;
        chk(bus_grant == 1'b1, "R10 not same clock", bus_grant, 1);
        @(posedge clk); @(negedge clk);
        chk(bus_grant == 1'b0 && ctl_oe == 1'b1, "R10 dropped", {bus_grant, ctl_oe}, 2'b01);

        // R11 hold raised mid transfer
        run_vec(VEC[4], 1'b1, 1'b0);

        // R12 short reset pulse mid transfer has no effect
        run_vec(VEC[1], 1'b0, 1'b1);

        // R12 long reset pulse aborts a read
        @(negedge clk);
        req_valid = 1'b1; req_addr = 20'h0BEEF; req_write = 1'b0; req_mem = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; bus_rdy = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_strb_n == 1'b0, "R12 not yet reset", rd_strb_n, 0);
        @(posedge clk); @(negedge clk);
        chk(rd_strb_n && xcvr_en_n && !addr_strobe && !rsp_valid, "R12 aborted",
            {rd_strb_n, xcvr_en_n, addr_strobe, rsp_valid}, 4'b1100);
        chk(req_ready == 1'b1, "R12 idle", req_ready, 1);
        rst_n = 1'b1; bus_rdy = 1'b1;
        repeat (2) @(posedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule